// File: doc/BRIEF.md
# Relocatable On-Chip SRAM Controller

This block holds a 2 KB static memory that software can place anywhere in a 24-bit system address space, in 2 KB steps. A small register file, reached through a plain 16-bit peripheral port, holds a configuration word (a halt bit, a sticky remap lock, and an access-space field) and two base registers. The base registers hold the upper and lower parts of the window address. A separate request/response stream carries system bus traffic. Every accepted request gets exactly one response, which says whether the array claimed the access and, for a claimed read, carries the data.

The array wakes up halted. While it is halted it keeps its contents but claims no access, and only then can the window be moved. Once software sets the lock, the window is frozen until reset. The CPU copies address bit 19 into bits 23:20. A base whose bits 23:20 differ from its bit 19 therefore makes a window that is never claimed. The space field can restrict the array to program fetches.

The request port follows valid/ready rules. A request is accepted on a clock edge where `arr_valid` and `arr_ready` are both high. Its response appears on `rsp_valid` one cycle later. The response stays unchanged while `rsp_ready` is low. `arr_ready` is high whenever no response is pending or the pending one is being taken, so back-pressure on the response stalls new requests without losing any.

Top module: `sram_reloc_ctrl`

## Requirements
- R1: After reset the configuration word reads 0x8000 (halted, unlocked, space 0), and both base registers and the test register read 0.
- R2: While the halt bit (config bit 15) is 1, every request gets a response with `rsp_ack`=0 and `rsp_rdata`=0, and writes leave the array unchanged. Contents written before a halt read back unchanged after the array resumes.
- R3: Writing 1 to config bit 9 sets the lock. Later config writes with bit 9 at 0 leave the lock at 1 until reset.
- R4: A write to either base register takes effect only if, before that write, the halt bit is 1 and the lock is 0. Otherwise the register keeps its value.
- R5: The register offsets select by `reg_off[2:1]` as follows: 0 = config, 1 = test, 2 = base high, 3 = base low. Config holds halt in bit 15, lock in bit 9 and space in bits 5:4. Base high holds address bits 23:16 in bits 7:0. Base low holds address bits 15:11 in bits 15:11. The test register reads 0 and ignores writes. All other bits read 0.
- R6: A request is claimed (`rsp_ack`=1) only when the halt bit is 0 and `arr_addr[23:11]` equals the base.
- R7: When base bits 23:20 are not all equal to base bit 19, no request is claimed.
- R8: When space bit 4 is 1, a request with `arr_prog`=0 is not claimed, while a request with `arr_prog`=1 is. Space bit 5 has no effect.
- R9: A claimed access addresses word `arr_addr[10:1]` of 1024 sixteen-bit words. `arr_be[1]` enables bits 15:8 and `arr_be[0]` enables bits 7:0 on writes. Write responses and unclaimed responses carry `rsp_rdata`=0.
- R10: Each accepted request gives `rsp_valid` on the next cycle. A response stays with stable data while `rsp_ready` is 0, and during that time `arr_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Register write when high |
| reg_off | input | 3 | Byte offset within the register block |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_off` |
| arr_valid | input | 1 | System request valid |
| arr_ready | output | 1 | System request accepted when high with valid |
| arr_addr | input | 24 | System byte address |
| arr_write | input | 1 | Request is a write |
| arr_be | input | 2 | Byte enables, [1] upper, [0] lower |
| arr_wdata | input | 16 | Write data |
| arr_prog | input | 1 | 1 = program access, 0 = data access |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_ack | output | 1 | Array claimed the request |
| rsp_rdata | output | 16 | Read data for claimed reads, else 0 |

## Verification
The assertions check on every cycle the properties that relate register state to what the block does next. They check that the lock never clears, that the base holds whenever remapping is forbidden, and that no claim follows an accepted request while halted, with an inconsistent base, or as a data access in program-only mode. They also check that a response accepted earlier holds still under back-pressure. The bench's scenarios are needed for the rest: data retained across a halt and resume, byte-lane merging, the word index at both ends of the array, the register bit layout and the reset values.

// File: rtl/sram_reloc_pkg.sv
package sram_reloc_pkg;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_TEST = 2'd1,
    SEL_BHI  = 2'd2,
    SEL_BLO  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       halt;
    logic       lock;
    logic [1:0] space;
  } cfg_t;

  localparam int CFG_HALT_BIT = 15;
  localparam int CFG_LOCK_BIT = 9;
  localparam int CFG_SPC_LSB  = 4;

endpackage

// File: rtl/sram_reloc_regs.sv
module sram_reloc_regs
  import sram_reloc_pkg::*;
#(
  parameter int AW      = 24,
  parameter int BLK_LSB = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_en,
  input  logic                  reg_we,
  input  logic [2:0]            reg_off,
  input  logic [15:0]           reg_wdata,
  output logic [15:0]           reg_rdata,
  output cfg_t                  cfg_q,
  output logic [AW-1:BLK_LSB]   base_q
);
  localparam int HI_W = AW - 16;
  localparam int LO_W = 16 - BLK_LSB;

  reg_sel_e sel;
  logic     remap_ok;
  logic     wr;

  assign sel      = reg_sel_e'(reg_off[2:1]);
  assign remap_ok = cfg_q.halt && !cfg_q.lock;
  assign wr       = reg_en && reg_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.halt  <= 1'b1;
      cfg_q.lock  <= 1'b0;
      cfg_q.space <= 2'b00;
      base_q      <= '0;
    end else if (wr) begin
      case (sel)
        SEL_CFG: begin
          cfg_q.halt  <= reg_wdata[CFG_HALT_BIT];
          cfg_q.lock  <= cfg_q.lock | reg_wdata[CFG_LOCK_BIT];
          cfg_q.space <= reg_wdata[CFG_SPC_LSB +: 2];
        end
        SEL_BHI: if (remap_ok) base_q[AW-1:16] <= reg_wdata[HI_W-1:0];
        SEL_BLO: if (remap_ok) base_q[15:BLK_LSB] <= reg_wdata[15:BLK_LSB];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_CFG: begin
        reg_rdata[CFG_HALT_BIT]         = cfg_q.halt;
        reg_rdata[CFG_LOCK_BIT]         = cfg_q.lock;
        reg_rdata[CFG_SPC_LSB +: 2]     = cfg_q.space;
      end
      SEL_BHI: reg_rdata = {{(16-HI_W){1'b0}}, base_q[AW-1:16]};
      SEL_BLO: reg_rdata = {base_q[15:BLK_LSB], {(16-LO_W){1'b0}}};
      default: reg_rdata = '0;
    endcase
  end

  logic unused_in;
  assign unused_in = &{1'b0, reg_off[0], reg_wdata};

  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.lock |=> cfg_q.lock);

  assert_base_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_q.halt && !cfg_q.lock) |=> $stable(base_q));

endmodule

// File: rtl/sram_reloc_match.sv
module sram_reloc_match
  import sram_reloc_pkg::*;
#(
  parameter int AW      = 24,
  parameter int BLK_LSB = 11,
  parameter int EXT_LSB = 20
) (
  input  logic [AW-1:0]         addr,
  input  logic                  prog,
  input  cfg_t                  cfg,
  input  logic [AW-1:BLK_LSB]   base,
  output logic                  alias_ok,
  output logic                  hit
);
  localparam int EXT_W = AW - EXT_LSB;

  logic win_eq;
  logic space_ok;

  assign alias_ok = (base[AW-1:EXT_LSB] == {EXT_W{base[EXT_LSB-1]}});
  assign win_eq   = (addr[AW-1:BLK_LSB] == base);
  assign space_ok = !cfg.space[0] || prog;
  assign hit      = !cfg.halt && alias_ok && win_eq && space_ok;

  logic unused_in;
  assign unused_in = &{1'b0, addr[BLK_LSB-1:0], cfg.lock, cfg.space[1]};

endmodule

// File: rtl/sram_reloc_array.sv
module sram_reloc_array #(
  parameter int WORDS = 1024,
  parameter int LANES = 2,
  localparam int IW   = $clog2(WORDS),
  localparam int DW   = 8 * LANES
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [LANES-1:0] be,
  input  logic [IW-1:0]    idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [7:0] lane_mem [WORDS];
    always_ff @(posedge clk) begin
      if (en && we && be[b]) lane_mem[idx] <= wdata[8*b +: 8];
      if (en && !we)         rdata[8*b +: 8] <= lane_mem[idx];
    end
  end

endmodule

// File: rtl/sram_reloc_ctrl.sv
module sram_reloc_ctrl
  import sram_reloc_pkg::*;
#(
  parameter int AW      = 24,
  parameter int BLK_LSB = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_en,
  input  logic        reg_we,
  input  logic [2:0]  reg_off,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        arr_valid,
  output logic        arr_ready,
  input  logic [23:0] arr_addr,
  input  logic        arr_write,
  input  logic [1:0]  arr_be,
  input  logic [15:0] arr_wdata,
  input  logic        arr_prog,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic        rsp_ack,
  output logic [15:0] rsp_rdata
);
  localparam int WORDS = 2 ** (BLK_LSB - 1);

  cfg_t                cfg;
  logic [AW-1:BLK_LSB] base;
  logic                hit;
  logic                alias_ok;
  logic                accept;
  logic [15:0]         mem_q;
  logic                rsp_valid_q, rsp_ack_q, rsp_rd_q;

  sram_reloc_regs #(.AW(AW), .BLK_LSB(BLK_LSB)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cfg_q(cfg), .base_q(base)
  );

  sram_reloc_match #(.AW(AW), .BLK_LSB(BLK_LSB)) u_match (
    .addr(arr_addr), .prog(arr_prog), .cfg(cfg), .base(base),
    .alias_ok(alias_ok), .hit(hit)
  );

  assign arr_ready = !rsp_valid_q || rsp_ready;
  assign accept    = arr_valid && arr_ready;

  sram_reloc_array #(.WORDS(WORDS), .LANES(2)) u_array (
    .clk(clk), .en(accept && hit), .we(arr_write), .be(arr_be),
    .idx(arr_addr[BLK_LSB-1:1]), .wdata(arr_wdata), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_ack_q   <= 1'b0;
      rsp_rd_q    <= 1'b0;
    end else if (arr_ready) begin
      rsp_valid_q <= arr_valid;
      rsp_ack_q   <= arr_valid && hit;
      rsp_rd_q    <= arr_valid && hit && !arr_write;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_ack   = rsp_ack_q;
  assign rsp_rdata = rsp_rd_q ? mem_q : 16'h0000;

  assert_halt_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg.halt) |=> !rsp_ack);

  assert_alias_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !alias_ok) |=> !rsp_ack);

  assert_space_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg.space[0] && !arr_prog) |=> !rsp_ack);

  assert_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (arr_addr[AW-1:BLK_LSB] != base)) |=> !rsp_ack);

  assert_rsp_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ack) && $stable(rsp_rdata)));

endmodule

// File: tb/sram_reloc_ctrl_bench.sv
module sram_reloc_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [2:0]  reg_off = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        arr_valid = 1'b0, arr_write = 1'b0, arr_prog = 1'b0;
  logic        arr_ready;
  logic [23:0] arr_addr = '0;
  logic [1:0]  arr_be = '0;
  logic [15:0] arr_wdata = '0;
  logic        rsp_valid, rsp_ack;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [16:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  sram_reloc_ctrl u_sram_reloc_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we), .reg_off(reg_off),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .arr_valid(arr_valid),
    .arr_ready(arr_ready), .arr_addr(arr_addr), .arr_write(arr_write), .arr_be(arr_be),
    .arr_wdata(arr_wdata), .arr_prog(arr_prog), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata)
  );

  // monitor: compares each consumed response with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R10 unexpected response ack=%0b data=%h expected none", rsp_ack, rsp_rdata);
      end else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rsp_ack, rsp_rdata} !== e) begin
          bad++;
          $display("FAIL %s ack/data actual=%0b/%h expected=%0b/%h", t, rsp_ack, rsp_rdata, e[16], e[15:0]);
        end
      end
    end
  end

  task automatic wreg(input logic [2:0] off, input logic [15:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_off = off; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic creg(input logic [2:0] off, input logic [15:0] e, input string t);
    @(negedge clk);
    reg_off = off;
    #0;
    total++;
    if (reg_rdata !== e) begin
      bad++;
      $display("FAIL %s reg[%0d] actual=%h expected=%h", t, off, reg_rdata, e);
    end
  endtask

  // driver: issues one request and pushes its expected response
  task automatic acc(input logic [23:0] a, input logic w, input logic [1:0] be,
                     input logic [15:0] d, input logic p, input logic eack,
                     input logic [15:0] edat, input string t);
    @(negedge clk);
    arr_valid = 1'b1; arr_addr = a; arr_write = w; arr_be = be; arr_wdata = d; arr_prog = p;
    while (!arr_ready) @(negedge clk);
    exp_q.push_back({eack, edat});
    tag_q.push_back(t);
    @(negedge clk);
    arr_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    creg(3'd0, 16'h8000, "R1 cfg reset");
    creg(3'd4, 16'h0000, "R1 base high reset");
    creg(3'd6, 16'h0000, "R1 base low reset");
    creg(3'd2, 16'h0000, "R1 test reset");

    // R2 halted: no claim
    acc(24'h000002, 1'b0, 2'b11, 16'h0, 1'b0, 1'b0, 16'h0000, "R2 halted read");

    // R5 layout and R4 remap while halted
    wreg(3'd6, 16'hFFFF);
    creg(3'd6, 16'hF800, "R5 base low bits");
    wreg(3'd6, 16'h0800);
    wreg(3'd4, 16'hFF02);
    creg(3'd4, 16'h0002, "R5 base high bits");
    wreg(3'd2, 16'hFFFF);
    creg(3'd2, 16'h0000, "R5 test ignores write");
    wreg(3'd0, 16'hFFFF);
    creg(3'd0, 16'h8230, "R5 cfg bit layout");
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    wreg(3'd6, 16'h0800);
    wreg(3'd4, 16'h0002);

    // run, then remap attempt must fail (R4)
    wreg(3'd0, 16'h0000);
    creg(3'd0, 16'h0000, "R2 cfg running");
    wreg(3'd4, 16'h0005);
    creg(3'd4, 16'h0002, "R4 remap while running blocked");

    // R6 R9 array behaviour
    acc(24'h020802, 1'b1, 2'b11, 16'h1234, 1'b0, 1'b1, 16'h0000, "R9 write word1");
    acc(24'h020802, 1'b0, 2'b11, 16'h0, 1'b0, 1'b1, 16'h1234, "R6 read word1");
    acc(24'h020802, 1'b1, 2'b10, 16'hAB00, 1'b0, 1'b1, 16'h0000, "R9 upper lane write");
    acc(24'h020802, 1'b0, 2'b11, 16'h0, 1'b0, 1'b1, 16'hAB34, "R9 upper lane merge");
    acc(24'h020800, 1'b1, 2'b11, 16'h0F0F, 1'b0, 1'b1, 16'h0000, "R9 write word0");
    acc(24'h020FFE, 1'b1, 2'b11, 16'h5A5A, 1'b0, 1'b1, 16'h0000, "R9 write word1023");
    acc(24'h020800, 1'b1, 2'b01, 16'hFFCD, 1'b0, 1'b1, 16'h0000, "R9 lower lane write");
    acc(24'h020FFE, 1'b0, 2'b11, 16'h0, 1'b0, 1'b1, 16'h5A5A, "R9 read word1023");
    acc(24'h020800, 1'b0, 2'b11, 16'h0, 1'b0, 1'b1, 16'h0FCD, "R9 lower lane merge");
    acc(24'h020000, 1'b0, 2'b11, 16'h0, 1'b0, 1'b0, 16'h0000, "R6 miss bit11");
    acc(24'h021002, 1'b0, 2'b11, 16'h0, 1'b0, 1'b0, 16'h0000, "R6 miss bit12");

    // R2 halt keeps data, halted write ignored
    wreg(3'd0, 16'h8000);
    acc(24'h020802, 1'b1, 2'b11, 16'hFFFF, 1'b0, 1'b0, 16'h0000, "R2 halted write");
    acc(24'h020802, 1'b0, 2'b11, 16'h0, 1'b1, 1'b0, 16'h0000, "R2 halted read");
    wreg(3'd0, 16'h0000);
    acc(24'h020802, 1'b0, 2'b11, 16'h0, 1'b0, 1'b1, 16'hAB34, "R2 retained after resume");

    // R8 space field
    wreg(3'd0, 16'h0010);
    acc(24'h020802, 1'b0, 2'b11, 16'h0, 1'b0, 1'b0, 16'h0000, "R8 data blocked");
    acc(24'h020802, 1'b0, 2'b11, 16'h0, 1'b1, 1'b1, 16'hAB34, "R8 program allowed");
    wreg(3'd0, 16'h0020);
    creg(3'd0, 16'h0020, "R5 cfg space readback");
    acc(24'h020802, 1'b0, 2'b11, 16'h0, 1'b0, 1'b1, 16'hAB34, "R8 upper space bit no effect");

    // R7 inconsistent upper nibble
    wreg(3'd0, 16'h8000);
    wreg(3'd4, 16'h0012);
    wreg(3'd0, 16'h0000);
    acc(24'h120802, 1'b0, 2'b11, 16'h0, 1'b0, 1'b0, 16'h0000, "R7 alias mismatch");
    acc(24'hF20802, 1'b0, 2'b11, 16'h0, 1'b0, 1'b0, 16'h0000, "R7 extended addr miss");
    wreg(3'd0, 16'h8000);
    wreg(3'd4, 16'h00FA);
    wreg(3'd0, 16'h0000);
    acc(24'hFA0802, 1'b1, 2'b11, 16'h7777, 1'b0, 1'b1, 16'h0000, "R7 consistent base write");
    acc(24'hFA0800, 1'b0, 2'b11, 16'h0, 1'b0, 1'b1, 16'h0FCD, "R7 same array after move");

    // R3 lock
    drain();
    wreg(3'd0, 16'h8200);
    creg(3'd0, 16'h8200, "R3 lock set");
    wreg(3'd4, 16'h0000);
    creg(3'd4, 16'h00FA, "R4 locked remap blocked");
    wreg(3'd0, 16'h8000);
    creg(3'd0, 16'h8200, "R3 lock survives clear");
    wreg(3'd0, 16'h0000);

    // R10 back-pressure
    drain();
    rsp_ready = 1'b0;
    acc(24'hFA0802, 1'b0, 2'b11, 16'h0, 1'b0, 1'b1, 16'h7777, "R10 stalled read");
    held = rsp_rdata;
    @(negedge clk);
    @(negedge clk);
    total++;
    if (!(rsp_valid && !arr_ready && rsp_rdata == held)) begin
      bad++;
      $display("FAIL R10 stall valid/ready/data actual=%0b/%0b/%h expected=1/0/%h",
               rsp_valid, arr_ready, rsp_rdata, held);
    end
    rsp_ready = 1'b1;
    drain();

    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R10 pending responses actual=%0d expected=0", exp_q.size());
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule